// File: doc/BRIEF.md
# Calendar Alarm Comparator with Interrupt Flags

This unit watches the current minute, hour, day and weekday of a calendar and raises a sticky alarm flag when the alarm setting is reached. Four alarm registers hold a BCD target for each field. Bit 7 of each one is an active-low enable: 0 includes that field in the comparison, 1 leaves it out. The comparison is evaluated on each time-update strobe. The flag is set only when the combined condition goes from false to true. A condition that merely persists does not set it again.

A second flag is set by a pulse from an external countdown timer. A control/status register holds both flags and an interrupt enable for each. Software clears a flag by writing 0 to its bit. Writing 1 leaves that flag unchanged, so one flag can be cleared without losing the other. The active-low interrupt output is low while either enabled flag is set. The asynchronous reset is released synchronously through two flops.

Top module: `alarm_irq_unit`

## Requirements
- R1: Two clock edges after reset is released, every alarm register reads 0x80 (field excluded, value 0), the control/status register reads 0x00 and irq_n is 1.
- R2: Only fields whose bit 7 is 0 take part in the match. A mismatch in an excluded field does not prevent the alarm.
- R3: On a tick where every included field equals the current time, and the previous tick did not match, the alarm flag (control/status bit 2) is 1 from the next clock edge. A match that persists across ticks does not set it again. Leaving the match and entering it again does set it again.
- R4: The alarm flag stays 1 until a control/status write with bit 2 equal to 0.
- R5: A control/status write (address 0) ANDs wdata bit 2 into the alarm flag and wdata bit 3 into the timer flag, so a written 1 keeps a flag. Bits 0 (alarm interrupt enable) and 1 (timer interrupt enable) are loaded directly. Bits 7:4 read 0.
- R6: A timer_evt pulse sets the timer flag (bit 3) at the next edge. A set wins over a clearing write in the same cycle.
- R7: irq_n is 0 exactly when (alarm flag AND bit 0) OR (timer flag AND bit 1).
- R8: With all four bit-7 values at 1, the alarm flag is never set.
- R9: Implemented alarm bits are minute 6:0, hour 5:0, day 5:0 and weekday 2:0, plus bit 7 in each. Other bits read 0.
- R10: Without tick, time changes neither set the flag nor update the match history.
- R11: Address map: 0 control/status, 1 minute, 2 hour, 3 day, 4 weekday. Addresses 5 to 7 read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| tick | input | 1 | time-update strobe |
| now_min | input | 7 | current minute, BCD |
| now_hour | input | 6 | current hour, BCD |
| now_day | input | 6 | current day, BCD |
| now_wday | input | 3 | current weekday 0-6 |
| timer_evt | input | 1 | countdown end pulse |
| reg_wr | input | 1 | register write strobe |
| reg_addr | input | 3 | register address |
| reg_wdata | input | 8 | write data |
| reg_rdata | output | 8 | read data (combinational) |
| alarm_flag | output | 1 | sticky alarm flag |
| timer_flag | output | 1 | sticky timer flag |
| irq_n | output | 1 | interrupt, active low |

## Verification
The hardest situation to reach is the alarm firing again after a clear. This needs the match history to be false at one tick and true at the next, while the time inputs stay matching. The stimulus walks a vector table that clears the flag and then holds a matching time across ticks. It steps the minute away and back, and it breaks the match through an included hour field. Each step checks whether the flag is set. Directed steps then collide a timer pulse with a clearing write, and they exclude all fields while the time matches.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;
  localparam int DW      = 8;
  localparam int AW      = 3;
  localparam int MIN_W   = 7;
  localparam int HOUR_W  = 6;
  localparam int DAY_W   = 6;
  localparam int WDAY_W  = 3;
  localparam int NFIELD  = 4;
  localparam int OFF_B   = DW - 1;

  localparam logic [AW-1:0] ADR_CS   = 3'd0;
  localparam logic [AW-1:0] ADR_MIN  = 3'd1;
  localparam logic [AW-1:0] ADR_HOUR = 3'd2;
  localparam logic [AW-1:0] ADR_DAY  = 3'd3;
  localparam logic [AW-1:0] ADR_WDAY = 3'd4;

  localparam int AIE_B = 0;
  localparam int TIE_B = 1;
  localparam int AF_B  = 2;
  localparam int TF_B  = 3;

  typedef struct packed {
    logic [MIN_W-1:0]  mn;
    logic [HOUR_W-1:0] hr;
    logic [DAY_W-1:0]  dy;
    logic [WDAY_W-1:0] wd;
  } cal_t;
endpackage

// File: rtl/alarm_regs.sv
module alarm_regs
  import alarm_irq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output cal_t          alm,
  output logic [NFIELD-1:0] off,
  output logic [DW-1:0] rdata
);
  cal_t              alm_q, alm_d;
  logic [NFIELD-1:0] off_q, off_d;

  always_comb begin
    alm_d = alm_q;
    off_d = off_q;
    if (wr) begin
      unique case (addr)
        ADR_MIN:  begin alm_d.mn = wdata[MIN_W-1:0];  off_d[0] = wdata[OFF_B]; end
        ADR_HOUR: begin alm_d.hr = wdata[HOUR_W-1:0]; off_d[1] = wdata[OFF_B]; end
        ADR_DAY:  begin alm_d.dy = wdata[DAY_W-1:0];  off_d[2] = wdata[OFF_B]; end
        ADR_WDAY: begin alm_d.wd = wdata[WDAY_W-1:0]; off_d[3] = wdata[OFF_B]; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alm_q <= '0;
      off_q <= '1;
    end else begin
      alm_q <= alm_d;
      off_q <= off_d;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      ADR_MIN:  rdata = {off_q[0], {(DW-1-MIN_W){1'b0}},  alm_q.mn};
      ADR_HOUR: rdata = {off_q[1], {(DW-1-HOUR_W){1'b0}}, alm_q.hr};
      ADR_DAY:  rdata = {off_q[2], {(DW-1-DAY_W){1'b0}},  alm_q.dy};
      ADR_WDAY: rdata = {off_q[3], {(DW-1-WDAY_W){1'b0}}, alm_q.wd};
      default:  rdata = '0;
    endcase
  end

  assign alm = alm_q;
  assign off = off_q;
endmodule

// File: rtl/alarm_match.sv
module alarm_match
  import alarm_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  cal_t              now,
  input  cal_t              alm,
  input  logic [NFIELD-1:0] off,
  output logic              hit
);
  logic [NFIELD-1:0] fld_eq;
  logic              all_eq;
  logic              prev_q, prev_d;

  assign fld_eq[0] = (now.mn == alm.mn);
  assign fld_eq[1] = (now.hr == alm.hr);
  assign fld_eq[2] = (now.dy == alm.dy);
  assign fld_eq[3] = (now.wd == alm.wd);

  assign all_eq = (|(~off)) && (&(fld_eq | off));

  always_comb begin
    prev_d = prev_q;
    if (tick) prev_d = all_eq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  assign hit = tick && all_eq && !prev_q;

  AST_HIT_ON_TICK:  assert property (@(posedge clk) disable iff (!rst_n) hit |-> tick);  // R10
  AST_NO_REFIRE:    assert property (@(posedge clk) disable iff (!rst_n) hit |=> !hit);  // R3
  AST_ALL_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (&off) |-> !hit); // R8
endmodule

// File: rtl/irq_flags.sv
module irq_flags
  import alarm_irq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          alarm_hit,
  input  logic          timer_evt,
  output logic          af,
  output logic          tf,
  output logic          aie,
  output logic          tie,
  output logic          irq_n
);
  logic af_q, af_d, tf_q, tf_d, aie_q, aie_d, tie_q, tie_d;

  always_comb begin
    af_d  = af_q;
    tf_d  = tf_q;
    aie_d = aie_q;
    tie_d = tie_q;
    if (wr) begin
      af_d  = af_q & wdata[AF_B];
      tf_d  = tf_q & wdata[TF_B];
      aie_d = wdata[AIE_B];
      tie_d = wdata[TIE_B];
    end
    if (alarm_hit) af_d = 1'b1;
    if (timer_evt) tf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      af_q <= 1'b0; tf_q <= 1'b0; aie_q <= 1'b0; tie_q <= 1'b0;
    end else begin
      af_q <= af_d; tf_q <= tf_d; aie_q <= aie_d; tie_q <= tie_d;
    end
  end

  assign af    = af_q;
  assign tf    = tf_q;
  assign aie   = aie_q;
  assign tie   = tie_q;
  assign irq_n = ~((af_q & aie_q) | (tf_q & tie_q));

  AST_AF_SOURCE: assert property (@(posedge clk) disable iff (!rst_n) $rose(af_q) |-> $past(alarm_hit)); // R3
  AST_AF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
                   (af_q && !(wr && !wdata[AF_B])) |=> af_q);                                  // R4
  AST_AF_CLEAR:  assert property (@(posedge clk) disable iff (!rst_n)
                   (wr && !wdata[AF_B] && !alarm_hit) |=> !af_q);                              // R5
  AST_TF_SET:    assert property (@(posedge clk) disable iff (!rst_n) timer_evt |=> tf_q);     // R6
endmodule

// File: rtl/alarm_irq_unit.sv
module alarm_irq_unit
  import alarm_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [MIN_W-1:0]  now_min,
  input  logic [HOUR_W-1:0] now_hour,
  input  logic [DAY_W-1:0]  now_day,
  input  logic [WDAY_W-1:0] now_wday,
  input  logic              timer_evt,
  input  logic              reg_wr,
  input  logic [AW-1:0]     reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              alarm_flag,
  output logic              timer_flag,
  output logic              irq_n
);
  logic [1:0]        rst_sync;
  logic              rst_q;
  cal_t              now, alm;
  logic [NFIELD-1:0] off;
  logic [DW-1:0]     alm_rdata;
  logic              hit, aie, tie;
  logic              cs_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  assign now   = '{mn: now_min, hr: now_hour, dy: now_day, wd: now_wday};
  assign cs_wr = reg_wr && (reg_addr == ADR_CS);

  alarm_regs u_regs (
    .clk(clk), .rst_n(rst_q), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .alm(alm), .off(off), .rdata(alm_rdata)
  );

  alarm_match u_match (
    .clk(clk), .rst_n(rst_q), .tick(tick), .now(now), .alm(alm), .off(off), .hit(hit)
  );

  irq_flags u_flags (
    .clk(clk), .rst_n(rst_q), .wr(cs_wr), .wdata(reg_wdata), .alarm_hit(hit),
    .timer_evt(timer_evt), .af(alarm_flag), .tf(timer_flag), .aie(aie), .tie(tie),
    .irq_n(irq_n)
  );

  always_comb begin
    if (reg_addr == ADR_CS) begin
      reg_rdata        = '0;
      reg_rdata[AIE_B] = aie;
      reg_rdata[TIE_B] = tie;
      reg_rdata[AF_B]  = alarm_flag;
      reg_rdata[TF_B]  = timer_flag;
    end else begin
      reg_rdata = alm_rdata;
    end
  end

  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_q)
                       !irq_n |-> (alarm_flag || timer_flag));  // R7
endmodule

// File: tb/tb_alarm_irq_unit.sv
module tb_alarm_irq_unit;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick, timer_evt, reg_wr;
  logic [6:0] now_min;
  logic [5:0] now_hour, now_day;
  logic [2:0] now_wday;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       alarm_flag, timer_flag, irq_n;
  int         n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  alarm_irq_unit dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .now_min(now_min), .now_hour(now_hour),
    .now_day(now_day), .now_wday(now_wday), .timer_evt(timer_evt), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .alarm_flag(alarm_flag), .timer_flag(timer_flag), .irq_n(irq_n)
  );

  // {clear_first, minute[6:0], hour[5:0], tick, expected alarm flag}
  localparam logic [15:0] VEC [8] = '{
    {1'b0, 7'h29, 6'h07, 1'b1, 1'b0},
    {1'b0, 7'h30, 6'h07, 1'b0, 1'b0},
    {1'b0, 7'h30, 6'h07, 1'b1, 1'b1},
    {1'b1, 7'h30, 6'h07, 1'b1, 1'b0},
    {1'b0, 7'h31, 6'h07, 1'b1, 1'b0},
    {1'b0, 7'h30, 6'h07, 1'b1, 1'b1},
    {1'b1, 7'h30, 6'h08, 1'b1, 1'b0},
    {1'b0, 7'h30, 6'h07, 1'b1, 1'b1}
  };

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic step(input logic t, input logic [6:0] m, input logic [5:0] h);
    @(negedge clk);
    tick = t; now_min = m; now_hour = h;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic pulse_tmr();
    @(negedge clk);
    timer_evt = 1'b1;
    @(negedge clk);
    timer_evt = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    rst_n = 1'b0; tick = 1'b0; timer_evt = 1'b0; reg_wr = 1'b0;
    reg_addr = '0; reg_wdata = '0;
    now_min = '0; now_hour = '0; now_day = 6'h15; now_wday = 3'd2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    for (int a = 1; a <= 4; a++) begin
      rd_reg(a[2:0], rd);
      check("R1 alarm reg reset", rd, 8'h80);
    end
    rd_reg(3'd0, rd);
    check("R1 status reset", rd, 8'h00);
    check("R1 irq_n reset", irq_n, 1);

    // R2: minute and hour included, day/weekday excluded with mismatching values
    wr_reg(3'd1, 8'h30);
    wr_reg(3'd2, 8'h07);
    wr_reg(3'd3, 8'h80 | 8'h01);
    for (int i = 0; i < 8; i++) begin
      if (VEC[i][15]) wr_reg(3'd0, 8'h08);
      step(VEC[i][1], VEC[i][14:8], VEC[i][7:2]);
      check($sformatf("R3 R10 R2 vector %0d", i), alarm_flag, VEC[i][0]);
    end

    // R4: flag persists across idle cycles and non-clearing writes
    repeat (5) @(negedge clk);
    check("R4 sticky idle", alarm_flag, 1);
    wr_reg(3'd0, 8'h04);
    check("R4 R5 write 1 keeps AF", alarm_flag, 1);

    // R6 and R5: timer flag, AND clear of one without the other
    pulse_tmr();
    check("R6 timer sets TF", timer_flag, 1);
    wr_reg(3'd0, 8'h04);
    check("R5 TF cleared", timer_flag, 0);
    check("R5 AF kept", alarm_flag, 1);
    rd_reg(3'd0, rd);
    check("R5 status readback", rd, 8'h04);

    // R7 interrupt combination
    wr_reg(3'd0, 8'h05);
    check("R7 AF&AIE drives irq", irq_n, 0);
    wr_reg(3'd0, 8'h01);
    check("R7 AF cleared irq high", irq_n, 1);
    pulse_tmr();
    check("R7 TF without TIE", irq_n, 1);
    wr_reg(3'd0, 8'h0A);
    check("R7 TF&TIE drives irq", irq_n, 0);
    rd_reg(3'd0, rd);
    check("R5 enables loaded", rd, 8'h0A);

    // R6 set wins over simultaneous clear
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 8'h00; timer_evt = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; timer_evt = 1'b0;
    check("R6 set beats clear", timer_flag, 1);
    wr_reg(3'd0, 8'h00);

    // R9 implemented bits
    wr_reg(3'd1, 8'hFF); rd_reg(3'd1, rd); check("R9 minute bits", rd, 8'hFF);
    wr_reg(3'd2, 8'hFF); rd_reg(3'd2, rd); check("R9 hour bits", rd, 8'hBF);
    wr_reg(3'd3, 8'hFF); rd_reg(3'd3, rd); check("R9 day bits", rd, 8'hBF);
    wr_reg(3'd4, 8'hFF); rd_reg(3'd4, rd); check("R9 weekday bits", rd, 8'h87);

    // R11 unused addresses
    wr_reg(3'd5, 8'h5A); rd_reg(3'd5, rd); check("R11 addr5 reads 0", rd, 8'h00);
    rd_reg(3'd1, rd); check("R11 write ignored", rd, 8'hFF);

    // R8 every field excluded, time equal to stored values
    wr_reg(3'd1, 8'hB0); wr_reg(3'd2, 8'h87);
    wr_reg(3'd3, 8'h95); wr_reg(3'd4, 8'h82);
    step(1'b1, 7'h29, 6'h07);
    step(1'b1, 7'h30, 6'h07);
    check("R8 all excluded", alarm_flag, 0);

    // R2 weekday alone included
    wr_reg(3'd4, 8'h02);
    step(1'b1, 7'h11, 6'h03);
    check("R2 weekday only", alarm_flag, 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule